// File: doc/BRIEF.md
# Ripple-Slice Arithmetic Logic Unit with Signed Compare

This unit is an integer arithmetic-logic unit built from a chain of one-bit slices. Each slice holds a full adder, a conditional inverter on each of its two operand bits, and a four-way result selector. The slices pass their carries in a ripple chain. The most-significant slice is a separate variant. It also finds signed overflow and produces a "set" bit. That set bit goes back to the compare input of bit 0. Every other slice has its compare input tied low. The result is that the select-compare operation returns 1 or 0 in bit 0 and zeros in all higher bits.

The unit is purely combinational. A 4-bit control word picks the function:

| Bit | Meaning |
|-----|---------|
| bit 3 | inverts operand A |
| bit 2 | inverts operand B and also drives the carry into bit 0 |
| bits 1:0 | select the slice output: 00 AND, 01 OR, 10 adder sum, 11 compare input |

From these fields come AND, OR, add, subtract, set-on-signed-less-than and NOR. The unit also drives:

- a zero flag;
- the carry out of the top slice;
- a signed overflow flag, qualified to the adder selection.

Top module: `slt_ripple_alu`

## Requirements
- R1: Control 0000 gives result = A AND B.
- R2: Control 0001 gives result = A OR B.
- R3: Control 0010 gives result = (A + B) mod 2^WIDTH, and carry_out = bit WIDTH of the unsigned sum A + B.
- R4: Control 0110 gives result = (A - B) mod 2^WIDTH. It is formed as A + NOT B + 1, so carry_out = 1 exactly when A >= B unsigned.
- R5: Control 0111 gives result bit 0 = 1 exactly when A < B as two's-complement numbers, and all higher result bits are 0. This holds also when A - B overflows.
- R6: Control 1100 gives result = NOT (A OR B).
- R7: With select 10 (add or subtract), overflow = 1 exactly when the exact signed sum of the conditioned operands and carry-in lies outside the WIDTH-bit two's-complement range.
- R8: With any select other than 10, overflow = 0.
- R9: zero = 1 exactly when every result bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| ctrl | input | 4 | Control word: bit 3 invert A, bit 2 invert B with carry-in, bits 1:0 select |
| result | output | WIDTH | Slice outputs |
| zero | output | 1 | All result bits are 0 |
| carry_out | output | 1 | Carry out of the most-significant slice |
| overflow | output | 1 | Signed overflow, add/subtract only |

## Verification
The unit holds no state, so any wrong internal signal shows at the ports in the same cycle as the operands that trigger it.

Some faults only appear for particular operand patterns:

- A broken link in the carry chain only appears when a carry has to cross that bit.
- A set bit that is not corrected for overflow only appears in compares where the subtraction overflows.
- A wrongly tied compare input shows up as a stray high bit in every compare result.

For these reasons, a narrow instance is swept over all operand pairs for every function. A full-width instance is then driven with sign-boundary corners and random operands.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_ADD  = 2'b10,
    SEL_LESS = 2'b11
  } alu_sel_e;

  localparam logic [3:0] CTL_AND = 4'b0000;
  localparam logic [3:0] CTL_OR  = 4'b0001;
  localparam logic [3:0] CTL_ADD = 4'b0010;
  localparam logic [3:0] CTL_SUB = 4'b0110;
  localparam logic [3:0] CTL_SLT = 4'b0111;
  localparam logic [3:0] CTL_NOR = 4'b1100;

  // One-bit full adder, returned as {carry, sum}.
  function automatic logic [1:0] full_add(input logic x, input logic y, input logic c);
    full_add = {(x & y) | (x & c) | (y & c), x ^ y ^ c};
  endfunction

  // Output selector of a single slice.
  function automatic logic slice_pick(input alu_sel_e sel, input logic x, input logic y,
                                      input logic sum, input logic less);
    case (sel)
      SEL_AND: slice_pick = x & y;
      SEL_OR:  slice_pick = x | y;
      SEL_ADD: slice_pick = sum;
      default: slice_pick = less;
    endcase
  endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_slice_pkg::*;
(
  input  logic     a,
  input  logic     b,
  input  logic     a_inv,
  input  logic     b_inv,
  input  logic     cin,
  input  logic     less,
  input  alu_sel_e sel,
  output logic     res,
  output logic     cout
);
  logic a_c, b_c, sum;

  always_comb begin
    a_c         = a ^ a_inv;
    b_c         = b ^ b_inv;
    {cout, sum} = full_add(a_c, b_c, cin);
    res         = slice_pick(sel, a_c, b_c, sum, less);
  end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
  import alu_slice_pkg::*;
(
  input  logic     a,
  input  logic     b,
  input  logic     a_inv,
  input  logic     b_inv,
  input  logic     cin,
  input  logic     less,
  input  alu_sel_e sel,
  output logic     res,
  output logic     cout,
  output logic     set,
  output logic     ovf
);
  logic a_c, b_c, sum;

  always_comb begin
    a_c         = a ^ a_inv;
    b_c         = b ^ b_inv;
    {cout, sum} = full_add(a_c, b_c, cin);
    res         = slice_pick(sel, a_c, b_c, sum, less);
    // carry into and out of the top bit disagree -> signed overflow
    ovf         = cin ^ cout;
    // true sign of the exact sum, repaired when the top bit overflowed
    set         = sum ^ ovf;
  end

  always_comb begin
    if (!$isunknown({a_c, b_c, sum, ovf})) begin
      // R7
      ovf_sign_chk: assert (!ovf || ((a_c == b_c) && (sum != a_c)))
        else $error("overflow without like-signed operands and flipped sign");
    end
  end
endmodule

// File: rtl/slt_ripple_alu.sv
module slt_ripple_alu
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             carry_out,
  output logic             overflow
);
  localparam int MSB = WIDTH - 1;

  logic       a_inv, b_inv;
  alu_sel_e   sel;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] less_in;
  logic             set_bit;
  logic             ovf_raw;

  assign a_inv    = ctrl[3];
  assign b_inv    = ctrl[2];
  assign sel      = alu_sel_e'(ctrl[1:0]);
  assign carry[0] = b_inv;
  // only bit 0 sees the compare outcome; the rest read constant zero
  assign less_in  = {{(WIDTH-1){1'b0}}, set_bit};

  genvar i;
  generate
    for (i = 0; i < MSB; i++) begin : g_slice
      alu_bit_slice u_bit (
        .a    (op_a[i]),
        .b    (op_b[i]),
        .a_inv(a_inv),
        .b_inv(b_inv),
        .cin  (carry[i]),
        .less (less_in[i]),
        .sel  (sel),
        .res  (result[i]),
        .cout (carry[i+1])
      );
    end
  endgenerate

  alu_msb_slice u_top (
    .a    (op_a[MSB]),
    .b    (op_b[MSB]),
    .a_inv(a_inv),
    .b_inv(b_inv),
    .cin  (carry[MSB]),
    .less (less_in[MSB]),
    .sel  (sel),
    .res  (result[MSB]),
    .cout (carry[WIDTH]),
    .set  (set_bit),
    .ovf  (ovf_raw)
  );

  assign carry_out = carry[WIDTH];
  assign overflow  = ovf_raw & (sel == SEL_ADD);
  assign zero      = ~|result;

  // operands as the slices see them, brought out for the checks below
  logic [WIDTH-1:0] a_eff, b_eff;
  logic [WIDTH:0]   wide_sum;
  assign a_eff    = a_inv ? ~op_a : op_a;
  assign b_eff    = b_inv ? ~op_b : op_b;
  assign wide_sum = {1'b0, a_eff} + {1'b0, b_eff} + {{WIDTH{1'b0}}, b_inv};

  always_comb begin
    if (!$isunknown({op_a, op_b, ctrl, result, carry_out, overflow})) begin
      // R8
      ovf_gate_chk: assert (sel == SEL_ADD || !overflow)
        else $error("overflow raised outside adder selection");
      // R3
      ripple_sum_chk: assert (sel != SEL_ADD || {carry_out, result} == wide_sum)
        else $error("ripple chain disagrees with word-level sum");
      // R5
      slt_upper_chk: assert (sel != SEL_LESS || result[WIDTH-1:1] == '0)
        else $error("compare result has upper bits set");
      // R5
      slt_sign_chk: assert (ctrl != CTL_SLT || result[0] == ($signed(op_a) < $signed(op_b)))
        else $error("compare bit disagrees with signed order");
      // R1
      and_fn_chk: assert (ctrl != CTL_AND || result == (op_a & op_b))
        else $error("AND output mismatch");
    end
  end
endmodule

// File: tb/test_slt_ripple_alu.sv
`timescale 1ns/1ps
module test_slt_ripple_alu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [3:0]  s_a, s_b, s_ctl, s_res;
  logic        s_zero, s_co, s_ovf;
  logic [31:0] w_a, w_b, w_res;
  logic [3:0]  w_ctl;
  logic        w_zero, w_co, w_ovf;

  slt_ripple_alu #(.WIDTH(4)) i_slt_ripple_alu_small (
    .op_a(s_a), .op_b(s_b), .ctrl(s_ctl), .result(s_res),
    .zero(s_zero), .carry_out(s_co), .overflow(s_ovf)
  );

  slt_ripple_alu #(.WIDTH(32)) i_slt_ripple_alu (
    .op_a(w_a), .op_b(w_b), .ctrl(w_ctl), .result(w_res),
    .zero(w_zero), .carry_out(w_co), .overflow(w_ovf)
  );

  logic [3:0] codes [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Arithmetic model of the requirements, independent of the slice structure.
  task automatic model(input int w, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] c, output logic [31:0] r, output logic co,
                       output logic ov, output logic z);
    longint mask, ua, ub, cin, usum, sa, sb, ssum, hi, lo;
    mask = (longint'(1) << w) - 1;
    ua   = (c[3] ? ~longint'(a) : longint'(a)) & mask;
    ub   = (c[2] ? ~longint'(b) : longint'(b)) & mask;
    cin  = longint'(c[2]);
    usum = ua + ub + cin;
    co   = ((usum >> w) & 1) != 0;
    sa   = ((ua >> (w - 1)) & 1) != 0 ? ua - (longint'(1) << w) : ua;
    sb   = ((ub >> (w - 1)) & 1) != 0 ? ub - (longint'(1) << w) : ub;
    ssum = sa + sb + cin;
    hi   = (longint'(1) << (w - 1)) - 1;
    lo   = -(longint'(1) << (w - 1));
    ov   = (c[1:0] == 2'b10) && (ssum > hi || ssum < lo);
    case (c[1:0])
      2'b00:   r = 32'(ua & ub);
      2'b01:   r = 32'(ua | ub);
      2'b10:   r = 32'(usum & mask);
      default: r = (ssum < 0) ? 32'd1 : 32'd0;
    endcase
    z = (r == 32'd0);
  endtask

  function automatic string res_tag(input logic [3:0] c);
    case (c)
      4'b0000: return "R1 and";
      4'b0001: return "R2 or";
      4'b0010: return "R3 add";
      4'b0110: return "R4 sub";
      4'b0111: return "R5 slt";
      default: return "R6 nor";
    endcase
  endfunction

  task automatic apply(input int w, input logic [31:0] a, input logic [31:0] b, input logic [3:0] c);
    logic [31:0] er, ar;
    logic eco, eov, ez, aco, aov, az;
    @(posedge clk);
    if (w == 4) begin
      s_a = a[3:0]; s_b = b[3:0]; s_ctl = c;
    end else begin
      w_a = a; w_b = b; w_ctl = c;
    end
    @(negedge clk);
    model(w, a, b, c, er, eco, eov, ez);
    if (w == 4) begin
      ar = {28'd0, s_res}; aco = s_co; aov = s_ovf; az = s_zero;
    end else begin
      ar = w_res; aco = w_co; aov = w_ovf; az = w_zero;
    end
    check(res_tag(c), ar, er);
    if (c == 4'b0010) check("R3 carry", {31'd0, aco}, {31'd0, eco});
    if (c == 4'b0110) check("R4 carry", {31'd0, aco}, {31'd0, eco});
    if (c[1:0] == 2'b10) check("R7 overflow", {31'd0, aov}, {31'd0, eov});
    else                 check("R8 overflow", {31'd0, aov}, 32'd0);
    check("R9 zero", {31'd0, az}, {31'd0, ez});
  endtask

  logic [31:0] corners [8] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h8000_0000,
                               32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h5555_5555, 32'hAAAA_AAAA};

  initial begin
    s_a = '0; s_b = '0; s_ctl = 4'b0010;
    w_a = '0; w_b = '0; w_ctl = 4'b0010;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle inputs: sum of zeros, zero flag high (R9)
    @(negedge clk);
    check("R9 idle zero", {31'd0, w_zero}, 32'd1);
    check("R3 idle result", w_res, 32'd0);
    // Exhaustive sweep of the narrow instance
    for (int k = 0; k < 6; k++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          apply(4, 32'(a), 32'(b), codes[k]);
    // Sign-boundary corners on the full-width instance
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply(32, corners[i], corners[j], codes[k]);
    // Random operands
    for (int n = 0; n < 200; n++)
      for (int k = 0; k < 6; k++)
        apply(32, $urandom, $urandom, codes[k]);
    // Equal operands: subtract yields zero with carry, compare yields 0 (R4, R5)
    apply(32, 32'h1234_5678, 32'h1234_5678, 4'b0110);
    apply(32, 32'h8000_0000, 32'h8000_0000, 4'b0111);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule